// File: doc/BRIEF.md
# Two-Way Set-Associative Cache with LRU Replacement

This block sits between a processor-side request port and a block-wide next-level memory port. The word address it receives breaks into three fields: a tag, a set index and a word offset. The index picks one set. Both ways of that set compare their stored tags with the request tag in parallel, and each comparison counts only when its way is valid. On a hit the matching way supplies the data. On a miss the line goes into the lowest-numbered invalid way of the set. If both ways are already valid, it replaces the way that one per-set recency bit marks as least recently used.

The parameter `WRITE_BACK` selects the write policy. In write-back mode a write hit changes only the cached line and marks it dirty. A dirty line is written to memory as a whole block before its way is refilled. In write-through mode every write is sent to memory as a single-word strobed write. A write miss in this mode does not allocate a line.

Both data ports use valid/ready handshakes. The cache accepts a request when `req_valid` and `req_ready` are both high. `req_ready` stays low from acceptance until the response has been given. Each accepted request gets exactly one `rsp_valid` pulse, and that pulse cannot be back-pressured. On the memory side, a request with `mem_req_valid` high keeps its fields stable until `mem_req_ready` is high. After a read has been accepted, the data returns on a one-cycle `mem_rsp_valid` pulse no earlier than the next cycle.

Top module: `cache2w_lru`

## Requirements
- R1: After reset every valid, dirty and recency bit is cleared, so the first access to any address is a miss. While idle, `req_ready` is high and both `rsp_valid` and `mem_req_valid` are low.
- R2: With one-word lines and two sets, bit 0 of `req_addr` selects the set and bits 7..1 form the tag. A read returns the last value written to that address, or the memory contents if the address has never been written.
- R3: A read hit issues no memory request. Its `rsp_valid` rises on the second clock edge after acceptance.
- R4: On a miss, a set with an invalid way fills the lowest-numbered invalid way.
- R5: When both ways are valid, a miss replaces the way accessed least recently. Reads and writes both count as accesses.
- R6: After a hit or a fill, the set's recency bit points at the other way.
- R7: In write-back mode, a write hit updates only the cache and issues no memory write.
- R8: In write-back mode, a dirty victim is written as a full block, with all strobes set, before the refill read. A clean victim causes no write.
- R9: In write-through mode, each write hit updates the cached word and also issues one memory write with exactly the strobe of that word set.
- R10: In write-through mode, a write miss sends the word to memory without a refill read and allocates no line. A later read of that address misses.
- R11: `req_ready` falls in the cycle after acceptance and stays low until the response. `rsp_valid` is a one-cycle pulse, followed by `req_ready` high.
- R12: With two sets and one-word lines, a read sequence to addresses 0,2,0,1,4,0,2,3,5,4 after reset produces miss, miss, hit, miss, miss, hit, miss, miss, miss, miss.
- R13: While `mem_req_valid` is high and `mem_req_ready` is low, the memory request holds its valid, address, direction and data stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request valid |
| req_ready | output | 1 | Cache can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | DATA_W | Read data (written word for writes) |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_write | output | 1 | 1 = block write, 0 = block read |
| mem_req_addr | output | ADDR_W-log2(WORDS) | Block address |
| mem_req_wdata | output | WORDS*DATA_W | Block write data |
| mem_req_wstrb | output | WORDS | Per-word write enables |
| mem_rsp_valid | input | 1 | Refill data valid |
| mem_rsp_rdata | input | WORDS*DATA_W | Refill block data |

## Verification
The checker watches the handshake rules on every cycle. It checks that ready drops after acceptance, that the response is a single pulse, that the cache is quiet while idle, and that a stalled memory request holds steady. It also checks the strobe pattern each policy must produce on writes. Hit and miss decisions, the choice of victim, recency updates, dirty writebacks and returned data can be seen only across a sequence of accesses. The bench scenarios therefore compare each response and each count of memory reads and writes against a separate two-way recency model, driven by the fixed trace, directed policy cases and random traffic.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;
  localparam int WAYS = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_WBACK,
    ST_FILL,
    ST_WTHRU,
    ST_RESP
  } cstate_t;
endpackage

// File: rtl/cache2w_way.sv
module cache2w_way #(
  parameter int SETS   = 2,
  parameter int TAG_W  = 7,
  parameter int LINE_W = 16,
  localparam int SET_W = $clog2(SETS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SET_W-1:0]  set_sel,
  output logic              rd_valid,
  output logic              rd_dirty,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [LINE_W-1:0] rd_line,
  input  logic              wr_en,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [LINE_W-1:0] wr_line,
  input  logic              wr_dirty
);
  logic [SETS-1:0]   valid_q;
  logic [SETS-1:0]   dirty_q;
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [LINE_W-1:0] line_q [SETS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (wr_en) begin
      valid_q[set_sel] <= 1'b1;
      dirty_q[set_sel] <= wr_dirty;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[set_sel]  <= wr_tag;
      line_q[set_sel] <= wr_line;
    end
  end

  assign rd_valid = valid_q[set_sel];
  assign rd_dirty = dirty_q[set_sel];
  assign rd_tag   = tag_q[set_sel];
  assign rd_line  = line_q[set_sel];
endmodule

// File: rtl/cache2w_recency.sv
module cache2w_recency #(
  parameter int SETS = 2,
  localparam int SET_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] set_sel,
  output logic             evict_way,
  input  logic             touch_en,
  input  logic             touch_way
);
  logic [SETS-1:0] older_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        older_q <= '0;
    else if (touch_en) older_q[set_sel] <= ~touch_way;
  end

  assign evict_way = older_q[set_sel];
endmodule

// File: rtl/cache2w_lookup.sv
module cache2w_lookup
  import cache2w_pkg::*;
#(
  parameter int TAG_W = 7
) (
  input  logic             way_valid [WAYS],
  input  logic [TAG_W-1:0] way_tag   [WAYS],
  input  logic [TAG_W-1:0] req_tag,
  input  logic             lru_way,
  output logic             hit,
  output logic             hit_way,
  output logic             victim_way
);
  logic [WAYS-1:0] match;

  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign match[g] = way_valid[g] && (way_tag[g] == req_tag);
  end

  assign hit     = |match;
  assign hit_way = match[1] && !match[0];

  always_comb begin
    if (!way_valid[0])      victim_way = 1'b0;
    else if (!way_valid[1]) victim_way = 1'b1;
    else                    victim_way = lru_way;
  end
endmodule

// File: rtl/cache2w_lru.sv
module cache2w_lru
  import cache2w_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 16,
  parameter int WORDS      = 1,
  parameter int SETS       = 2,
  parameter bit WRITE_BACK = 1'b1,
  localparam int OFF_W  = $clog2(WORDS),
  localparam int SET_W  = $clog2(SETS),
  localparam int BLK_W  = ADDR_W - OFF_W,
  localparam int TAG_W  = BLK_W - SET_W,
  localparam int LINE_W = WORDS * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [BLK_W-1:0]  mem_req_addr,
  output logic [LINE_W-1:0] mem_req_wdata,
  output logic [WORDS-1:0]  mem_req_wstrb,
  input  logic              mem_rsp_valid,
  input  logic [LINE_W-1:0] mem_rsp_rdata
);
  cstate_t           st;
  logic [ADDR_W-1:0] r_addr;
  logic              r_write;
  logic [DATA_W-1:0] r_wdata;
  logic              r_way;
  logic              fill_sent;
  logic [DATA_W-1:0] rdata_q;
  logic              m_valid, m_write;
  logic [BLK_W-1:0]  m_addr;
  logic [LINE_W-1:0] m_wdata;
  logic [WORDS-1:0]  m_strb;

  logic [BLK_W-1:0]  blk;
  logic [SET_W-1:0]  r_set;
  logic [TAG_W-1:0]  r_tag;
  int                word_idx;
  logic [WORDS-1:0]  word_strb;

  assign blk      = r_addr[ADDR_W-1:OFF_W];
  assign r_set    = blk[SET_W-1:0];
  assign r_tag    = blk[BLK_W-1:SET_W];
  assign word_idx = int'(r_addr % ADDR_W'(WORDS));

  always_comb begin
    for (int k = 0; k < WORDS; k++) word_strb[k] = (k == word_idx);
  end

  function automatic logic [LINE_W-1:0] put_word(input logic [LINE_W-1:0] line,
                                                 input int idx,
                                                 input logic [DATA_W-1:0] w);
    logic [LINE_W-1:0] o;
    o = line;
    for (int k = 0; k < WORDS; k++)
      if (k == idx) o[k*DATA_W +: DATA_W] = w;
    return o;
  endfunction

  function automatic logic [DATA_W-1:0] get_word(input logic [LINE_W-1:0] line,
                                                 input int idx);
    logic [DATA_W-1:0] o;
    o = '0;
    for (int k = 0; k < WORDS; k++)
      if (k == idx) o = line[k*DATA_W +: DATA_W];
    return o;
  endfunction

  // storage for both ways
  logic              way_valid [WAYS];
  logic              way_dirty [WAYS];
  logic [TAG_W-1:0]  way_tag   [WAYS];
  logic [LINE_W-1:0] way_line  [WAYS];
  logic [WAYS-1:0]   wr_en;
  logic [LINE_W-1:0] wr_line;
  logic              wr_dirty;

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    cache2w_way #(.SETS(SETS), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_way (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_sel  (r_set),
      .rd_valid (way_valid[g]),
      .rd_dirty (way_dirty[g]),
      .rd_tag   (way_tag[g]),
      .rd_line  (way_line[g]),
      .wr_en    (wr_en[g]),
      .wr_tag   (r_tag),
      .wr_line  (wr_line),
      .wr_dirty (wr_dirty)
    );
  end

  logic lru_way, touch_en, touch_way;
  logic hit, hit_way, victim;

  cache2w_recency #(.SETS(SETS)) u_recency (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_sel   (r_set),
    .evict_way (lru_way),
    .touch_en  (touch_en),
    .touch_way (touch_way)
  );

  cache2w_lookup #(.TAG_W(TAG_W)) u_lookup (
    .way_valid  (way_valid),
    .way_tag    (way_tag),
    .req_tag    (r_tag),
    .lru_way    (lru_way),
    .hit        (hit),
    .hit_way    (hit_way),
    .victim_way (victim)
  );

  logic [LINE_W-1:0] hit_line, upd_line, fill_line;
  logic              fill_done;

  assign hit_line  = hit_way ? way_line[1] : way_line[0];
  assign upd_line  = r_write ? put_word(hit_line, word_idx, r_wdata) : hit_line;
  assign fill_line = r_write ? put_word(mem_rsp_rdata, word_idx, r_wdata) : mem_rsp_rdata;
  assign fill_done = (st == ST_FILL) && fill_sent && mem_rsp_valid;

  // array updates on hit and on refill
  always_comb begin
    wr_en     = '0;
    wr_line   = upd_line;
    wr_dirty  = 1'b0;
    touch_en  = 1'b0;
    touch_way = 1'b0;
    if (st == ST_LOOKUP && hit) begin
      touch_en  = 1'b1;
      touch_way = hit_way;
      if (r_write) begin
        wr_en[hit_way] = 1'b1;
        wr_dirty       = WRITE_BACK;
      end
    end else if (fill_done) begin
      wr_en[r_way] = 1'b1;
      wr_line      = fill_line;
      wr_dirty     = WRITE_BACK && r_write;
      touch_en     = 1'b1;
      touch_way    = r_way;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      r_addr    <= '0;
      r_write   <= 1'b0;
      r_wdata   <= '0;
      r_way     <= 1'b0;
      fill_sent <= 1'b0;
      rdata_q   <= '0;
      m_valid   <= 1'b0;
      m_write   <= 1'b0;
      m_addr    <= '0;
      m_wdata   <= '0;
      m_strb    <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (req_valid) begin
          r_addr  <= req_addr;
          r_write <= req_write;
          r_wdata <= req_wdata;
          st      <= ST_LOOKUP;
        end
        ST_LOOKUP: begin
          if (hit) begin
            rdata_q <= get_word(upd_line, word_idx);
            if (r_write && !WRITE_BACK) begin
              m_valid <= 1'b1;
              m_write <= 1'b1;
              m_addr  <= blk;
              m_wdata <= upd_line;
              m_strb  <= word_strb;
              st      <= ST_WTHRU;
            end else begin
              st <= ST_RESP;
            end
          end else if (r_write && !WRITE_BACK) begin
            rdata_q <= r_wdata;
            m_valid <= 1'b1;
            m_write <= 1'b1;
            m_addr  <= blk;
            m_wdata <= put_word('0, word_idx, r_wdata);
            m_strb  <= word_strb;
            st      <= ST_WTHRU;
          end else begin
            r_way   <= victim;
            m_valid <= 1'b1;
            if (way_valid[victim] && way_dirty[victim]) begin
              m_write <= 1'b1;
              m_addr  <= {way_tag[victim], r_set};
              m_wdata <= way_line[victim];
              m_strb  <= '1;
              st      <= ST_WBACK;
            end else begin
              m_write   <= 1'b0;
              m_addr    <= blk;
              m_strb    <= '0;
              fill_sent <= 1'b0;
              st        <= ST_FILL;
            end
          end
        end
        ST_WBACK: if (mem_req_ready) begin
          m_write   <= 1'b0;
          m_addr    <= blk;
          m_strb    <= '0;
          fill_sent <= 1'b0;
          st        <= ST_FILL;
        end
        ST_FILL: begin
          if (m_valid && mem_req_ready) begin
            m_valid   <= 1'b0;
            fill_sent <= 1'b1;
          end
          if (fill_done) begin
            rdata_q <= get_word(fill_line, word_idx);
            st      <= ST_RESP;
          end
        end
        ST_WTHRU: if (mem_req_ready) begin
          m_valid <= 1'b0;
          st      <= ST_RESP;
        end
        ST_RESP: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (st == ST_IDLE);
  assign rsp_valid     = (st == ST_RESP);
  assign rsp_rdata     = rdata_q;
  assign mem_req_valid = m_valid;
  assign mem_req_write = m_write;
  assign mem_req_addr  = m_addr;
  assign mem_req_wdata = m_wdata;
  assign mem_req_wstrb = m_strb;
endmodule

// File: rtl/cache2w_lru_chk.sv
module cache2w_lru_chk #(
  parameter int BLK_W      = 8,
  parameter int LINE_W     = 16,
  parameter int WORDS      = 1,
  parameter bit WRITE_BACK = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_write,
  input logic [BLK_W-1:0]  mem_req_addr,
  input logic [LINE_W-1:0] mem_req_wdata,
  input logic [WORDS-1:0]  mem_req_wstrb
);
  assert_ready_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_rsp_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready));

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_req_valid && !rsp_valid));

  assert_mem_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write) && $stable(mem_req_wdata)));

  assert_wb_full_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (WRITE_BACK && mem_req_valid && mem_req_write) |-> (mem_req_wstrb == {WORDS{1'b1}}));

  assert_wt_one_word_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!WRITE_BACK && mem_req_valid && mem_req_write) |-> ($countones(mem_req_wstrb) == 1));
endmodule

bind cache2w_lru cache2w_lru_chk #(
  .BLK_W(BLK_W), .LINE_W(LINE_W), .WORDS(WORDS), .WRITE_BACK(WRITE_BACK)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .rsp_valid     (rsp_valid),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_write (mem_req_write),
  .mem_req_addr  (mem_req_addr),
  .mem_req_wdata (mem_req_wdata),
  .mem_req_wstrb (mem_req_wstrb)
);

// File: tb/cache2w_lru_bench.sv
`timescale 1ns/1ps

module cache2w_memsim #(
  parameter int BLK_W  = 8,
  parameter int DATA_W = 16,
  parameter int WORDS  = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [BLK_W-1:0]        req_addr,
  input  logic [WORDS*DATA_W-1:0] req_wdata,
  input  logic [WORDS-1:0]        req_wstrb,
  output logic                    rsp_valid,
  output logic [WORDS*DATA_W-1:0] rsp_rdata
);
  logic [WORDS*DATA_W-1:0] mem [2**BLK_W];
  int rd_cnt, wr_cnt;

  initial begin
    rd_cnt = 0;
    wr_cnt = 0;
    for (int b = 0; b < 2**BLK_W; b++)
      for (int w = 0; w < WORDS; w++)
        mem[b][w*DATA_W +: DATA_W] = DATA_W'(16'h5A00 ^ (b*WORDS + w));
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      req_ready <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      req_ready <= ~req_ready;
      rsp_valid <= 1'b0;
      if (req_valid && req_ready) begin
        if (req_write) begin
          for (int w = 0; w < WORDS; w++)
            if (req_wstrb[w]) mem[req_addr][w*DATA_W +: DATA_W] <= req_wdata[w*DATA_W +: DATA_W];
          wr_cnt <= wr_cnt + 1;
        end else begin
          rsp_valid <= 1'b1;
          rsp_rdata <= mem[req_addr];
          rd_cnt    <= rd_cnt + 1;
        end
      end
    end
  end
endmodule

module cache2w_lru_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic        req_valid [2];
  logic        req_ready [2];
  logic        req_write [2];
  logic [7:0]  req_addr  [2];
  logic [15:0] req_wdata [2];
  logic        rsp_valid [2];
  logic [15:0] rsp_rdata [2];
  logic        m_valid [2], m_ready [2], m_write [2], m_rvalid [2];
  logic [7:0]  m_addr [2];
  logic [15:0] m_wdata [2], m_rdata [2];
  logic [0:0]  m_strb [2];

  cache2w_lru #(.WRITE_BACK(1'b1)) u_cache2w_lru (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid[0]), .req_ready(req_ready[0]), .req_write(req_write[0]),
    .req_addr(req_addr[0]), .req_wdata(req_wdata[0]),
    .rsp_valid(rsp_valid[0]), .rsp_rdata(rsp_rdata[0]),
    .mem_req_valid(m_valid[0]), .mem_req_ready(m_ready[0]), .mem_req_write(m_write[0]),
    .mem_req_addr(m_addr[0]), .mem_req_wdata(m_wdata[0]), .mem_req_wstrb(m_strb[0]),
    .mem_rsp_valid(m_rvalid[0]), .mem_rsp_rdata(m_rdata[0]));

  cache2w_lru #(.WRITE_BACK(1'b0)) u_cache2w_lru_wt (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid[1]), .req_ready(req_ready[1]), .req_write(req_write[1]),
    .req_addr(req_addr[1]), .req_wdata(req_wdata[1]),
    .rsp_valid(rsp_valid[1]), .rsp_rdata(rsp_rdata[1]),
    .mem_req_valid(m_valid[1]), .mem_req_ready(m_ready[1]), .mem_req_write(m_write[1]),
    .mem_req_addr(m_addr[1]), .mem_req_wdata(m_wdata[1]), .mem_req_wstrb(m_strb[1]),
    .mem_rsp_valid(m_rvalid[1]), .mem_rsp_rdata(m_rdata[1]));

  cache2w_memsim u_mem0 (
    .clk(clk), .rst_n(rst_n), .req_valid(m_valid[0]), .req_ready(m_ready[0]),
    .req_write(m_write[0]), .req_addr(m_addr[0]), .req_wdata(m_wdata[0]), .req_wstrb(m_strb[0]),
    .rsp_valid(m_rvalid[0]), .rsp_rdata(m_rdata[0]));

  cache2w_memsim u_mem1 (
    .clk(clk), .rst_n(rst_n), .req_valid(m_valid[1]), .req_ready(m_ready[1]),
    .req_write(m_write[1]), .req_addr(m_addr[1]), .req_wdata(m_wdata[1]), .req_wstrb(m_strb[1]),
    .rsp_valid(m_rvalid[1]), .rsp_rdata(m_rdata[1]));

  // reference model: index 0 = write-back unit, 1 = write-through unit
  logic [15:0] shadow [2][256];
  bit          ref_val   [2][2][2];
  bit          ref_dirty [2][2][2];
  logic [6:0]  ref_tag   [2][2][2];
  int          ref_lru   [2][2];
  bit          last_hit;

  function automatic int rd_count(input int d);
    return (d == 0) ? u_mem0.rd_cnt : u_mem1.rd_cnt;
  endfunction
  function automatic int wr_count(input int d);
    return (d == 0) ? u_mem0.wr_cnt : u_mem1.wr_cnt;
  endfunction
  function automatic logic [15:0] mem_word(input int d, input int a);
    return (d == 0) ? u_mem0.mem[a] : u_mem1.mem[a];
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic access(input int d, input bit wr, input logic [7:0] a,
                        input logic [15:0] wd, input string req);
    int s, hw, v, exp_rd, exp_wr, rd0, wr0, lat;
    bit exp_hit, busy_ok;
    logic [6:0] t;
    logic [15:0] got;
    s = int'(a[0]);
    t = a[7:1];
    exp_hit = 0; hw = 0; exp_rd = 0; exp_wr = 0;
    for (int w = 0; w < 2; w++)
      if (ref_val[d][s][w] && ref_tag[d][s][w] == t) begin exp_hit = 1; hw = w; end
    if (exp_hit) begin
      ref_lru[d][s] = 1 - hw;
      if (wr) begin
        if (d == 0) ref_dirty[d][s][hw] = 1;
        else exp_wr = 1;
      end
    end else if (wr && d == 1) begin
      exp_wr = 1;
    end else begin
      v = !ref_val[d][s][0] ? 0 : (!ref_val[d][s][1] ? 1 : ref_lru[d][s]);
      if (ref_val[d][s][v] && ref_dirty[d][s][v]) exp_wr = 1;
      exp_rd = 1;
      ref_val[d][s][v]   = 1;
      ref_tag[d][s][v]   = t;
      ref_dirty[d][s][v] = (d == 0) && wr;
      ref_lru[d][s]      = 1 - v;
    end
    if (wr) shadow[d][a] = wd;

    @(negedge clk);
    req_valid[d] = 1'b1; req_write[d] = wr; req_addr[d] = a; req_wdata[d] = wd;
    rd0 = rd_count(d); wr0 = wr_count(d);
    while (!req_ready[d]) @(negedge clk);
    @(negedge clk);
    req_valid[d] = 1'b0;
    lat = 1; busy_ok = 1;
    while (!rsp_valid[d] && lat < 400) begin
      if (req_ready[d]) busy_ok = 0;
      @(negedge clk);
      lat++;
    end
    got = rsp_rdata[d];
    if (req_ready[d]) busy_ok = 0;
    check(rsp_valid[d] && busy_ok, "R11", "ready low until response", int'(busy_ok), 1);
    check(got == shadow[d][a], "R2", "response data", int'(got), int'(shadow[d][a]));
    check(rd_count(d) - rd0 == exp_rd, req, "refill reads (hit/miss)", rd_count(d) - rd0, exp_rd);
    check(wr_count(d) - wr0 == exp_wr, req, "memory writes", wr_count(d) - wr0, exp_wr);
    if (exp_hit && !wr) check(lat == 2, "R3", "read-hit latency", lat, 2);
    last_hit = (rd_count(d) == rd0);
    @(negedge clk);
    check(req_ready[d] && !rsp_valid[d], "R11", "ready after pulse", int'(req_ready[d]), 1);
  endtask

  task automatic t_reset();
    for (int d = 0; d < 2; d++) begin
      check(req_ready[d] == 1'b1, "R1", "idle ready", int'(req_ready[d]), 1);
      check(rsp_valid[d] == 1'b0, "R1", "idle rsp_valid", int'(rsp_valid[d]), 0);
      check(m_valid[d] == 1'b0, "R1", "idle mem_req_valid", int'(m_valid[d]), 0);
    end
  endtask

  task automatic t_trace();
    int addrs [10] = '{0, 2, 0, 1, 4, 0, 2, 3, 5, 4};
    bit hits  [10] = '{0, 0, 1, 0, 0, 1, 0, 0, 0, 0};
    for (int i = 0; i < 10; i++) begin
      access(0, 0, 8'(addrs[i]), 16'h0, "R12");
      check(last_hit == hits[i], "R12", "trace hit/miss", int'(last_hit), int'(hits[i]));
    end
  endtask

  task automatic t_fill_order();
    // set 1 of the write-through unit: 7 -> way0, 9 -> way1, 7 hit keeps both
    access(1, 0, 8'd7, 16'h0, "R4");
    access(1, 0, 8'd9, 16'h0, "R4");
    access(1, 0, 8'd7, 16'h0, "R6");
    check(last_hit == 1, "R4", "first fill kept in way 0", int'(last_hit), 1);
    access(1, 0, 8'd9, 16'h0, "R6");
    check(last_hit == 1, "R4", "second fill used empty way", int'(last_hit), 1);
  endtask

  task automatic t_write_touch();
    // write counts as access: 8 and 10 in set 0, write 8, then 12 must evict 10
    access(0, 0, 8'd8, 16'h0, "R5");
    access(0, 0, 8'd10, 16'h0, "R5");
    access(0, 1, 8'd8, 16'h1234, "R7");
    access(0, 0, 8'd12, 16'h0, "R5");
    access(0, 0, 8'd8, 16'h0, "R5");
    check(last_hit == 1, "R5", "written line survived", int'(last_hit), 1);
    access(0, 0, 8'd10, 16'h0, "R5");
    check(last_hit == 0, "R5", "older line evicted", int'(last_hit), 0);
  endtask

  task automatic t_writeback();
    access(0, 1, 8'd30, 16'hBEEF, "R8");
    access(0, 1, 8'd30, 16'hCAFE, "R7");
    check(mem_word(0, 30) == (16'h5A00 ^ 16'd30), "R7", "memory untouched by write hit",
          int'(mem_word(0, 30)), int'(16'h5A00 ^ 16'd30));
    access(0, 0, 8'd32, 16'h0, "R8");
    access(0, 0, 8'd34, 16'h0, "R8");
    check(mem_word(0, 30) == 16'hCAFE, "R8", "dirty victim written back",
          int'(mem_word(0, 30)), 16'hCAFE);
    access(0, 0, 8'd30, 16'h0, "R8");
    check(last_hit == 0, "R8", "evicted line misses", int'(last_hit), 0);
  endtask

  task automatic t_writethrough();
    access(1, 0, 8'd40, 16'h0, "R9");
    access(1, 1, 8'd40, 16'h7777, "R9");
    check(mem_word(1, 40) == 16'h7777, "R9", "memory word updated", int'(mem_word(1, 40)), 16'h7777);
    access(1, 0, 8'd40, 16'h0, "R9");
    check(last_hit == 1, "R9", "cache word updated (hit)", int'(last_hit), 1);
    access(1, 1, 8'd51, 16'h4242, "R10");
    check(last_hit == 1 && mem_word(1, 51) == 16'h4242, "R10", "no-allocate word write",
          int'(mem_word(1, 51)), 16'h4242);
    access(1, 0, 8'd51, 16'h0, "R10");
    check(last_hit == 0, "R10", "read after write miss misses", int'(last_hit), 0);
  endtask

  task automatic t_random();
    for (int i = 0; i < 300; i++) begin
      int d;
      bit wr;
      d  = i % 2;
      wr = ($urandom % 5) < 2;
      access(d, wr, 8'($urandom % 16), 16'($urandom), "R5");
    end
  endtask

  initial begin
    for (int d = 0; d < 2; d++) begin
      req_valid[d] = 0; req_write[d] = 0; req_addr[d] = 0; req_wdata[d] = 0;
      for (int a = 0; a < 256; a++) shadow[d][a] = 16'h5A00 ^ 16'(a);
      for (int s = 0; s < 2; s++) begin
        ref_lru[d][s] = 0;
        for (int w = 0; w < 2; w++) begin
          ref_val[d][s][w] = 0; ref_dirty[d][s][w] = 0; ref_tag[d][s][w] = '0;
        end
      end
    end
    void'($urandom(7));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_trace();
    t_fill_order();
    t_write_touch();
    t_writeback();
    t_writethrough();
    t_random();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule